// File: doc/BRIEF.md
# Multi-Target Interrupt Distributor

This block gathers sixteen software-raised interrupt IDs (0 to 15) and a parameterised set of wired interrupt lines, 32 by default, that map to IDs 16 and up. IDs 16 to 31 each belong to one fixed processor. IDs 32 and above are shared and can be routed to any set of processors. Every ID carries its own enable bit, a trigger mode (rising edge or level), an 8-bit priority value and a processor routing mask. Every ID also runs its own four-state lifecycle: idle, waiting, in service, and in service with a fresh request waiting.

For each processor port, an arbiter picks the most urgent enabled, waiting ID routed to that port. It shows that ID and its priority to the processor. The processor claims the ID with an acknowledge strobe and releases it with a completion strobe that carries the ID. Software programs the block through a narrow write port. Each write carries a kind code, a target ID and one data byte.

Per-ID lifecycle states and transitions: `ST_IDLE` to `ST_PEND` on a request. `ST_PEND` to `ST_ACT` on acknowledge, or to `ST_ACTPEND` if the request is still present. `ST_PEND` to `ST_IDLE` on a clear-pending write or when a level line falls. `ST_ACT` to `ST_ACTPEND` on a new request. `ST_ACT` to `ST_IDLE` (or to `ST_PEND` if a request arrives at the same moment) on completion. `ST_ACTPEND` to `ST_PEND` on completion. `ST_ACTPEND` to `ST_ACT` on a clear-pending write or when a level line falls.

Top module: `irq_distributor`

## Requirements
- R1: After reset, no port shows a valid interrupt and the global enable is off. Every ID is disabled with priority value 0xA0. Wired lines are level-sensitive. Shared IDs are routed to processor 0 (mask 2'b01).
- R2: While the global enable is off (write kind 0, data bit 0 = 0), no port shows a valid interrupt. Setting data bit 0 turns forwarding back on.
- R3: An ID whose enable bit is clear (write kind 1, data bit 0) never takes part in selection.
- R4: Each port shows the waiting, enabled ID whose routing mask has that port's bit set (bit c for port c) and whose priority value is lowest. On equal values, the lower ID wins. A route write (kind 4, data bits = mask) changes the routing of a shared ID.
- R5: With write kind 2 and data bit 0 = 1, a line becomes edge-triggered. A rising line shows as waiting on the second clock edge after it rises. A line held high raises nothing further.
- R6: For a level-sensitive line, the waiting state follows the line. A line that falls before acknowledge returns the ID to idle two edges later.
- R7: Acknowledge on a port claims the shown ID, which then stops being shown. If its level line is still high, the ID goes in service with a fresh request waiting.
- R8: An edge on an in-service ID records a fresh request without showing it. Further edges leave it in that state.
- R9: A completion naming an in-service ID returns it to idle. If a fresh request is waiting, the ID returns to waiting and is shown again.
- R10: A software-raise write (kind 7) to an ID from 0 to 15 marks it waiting. The same write sets its routing mask from the data bits. Both take effect on the next clock edge.
- R11: A set-pending write (kind 5) marks an ID waiting on the next clock edge. A clear-pending write (kind 6) removes the waiting request on the next clock edge.
- R12: IDs 16 to 23 are routed only to processor 0 and IDs 24 to 31 only to processor 1. Route writes to these IDs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NUM_LINES | Wired requests, bit k drives ID 16+k |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Write kind code (0 global enable … 7 software raise) |
| wr_id | input | IDW | Target ID of the write |
| wr_data | input | PRIO_W | Write data |
| ack | input | NUM_CPU | Per-port acknowledge of the shown ID |
| eoi | input | NUM_CPU | Per-port completion strobe |
| eoi_id | input | NUM_CPU*IDW | Per-port completed ID |
| irq_valid | output | NUM_CPU | Per-port interrupt shown |
| irq_id | output | NUM_CPU*IDW | Per-port shown ID |
| irq_prio | output | NUM_CPU*PRIO_W | Per-port shown priority |

## Verification
Writes, acknowledges and completions change the per-ID state on the clock edge where they are sampled. The port outputs are combinational from that state, so their effect is checked at the falling edge right after that rising edge. Wired lines pass through a two-flop history, so a line change is checked two rising edges later. Reads are taken one edge earlier to confirm the request is not yet visible. Every sample is taken at a falling edge, and all stimulus changes at a falling edge.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PEND    = 2'd1,
        ST_ACT     = 2'd2,
        ST_ACTPEND = 2'd3
    } irq_state_e;

    typedef enum logic [2:0] {
        WK_GCTL   = 3'd0,
        WK_ENABLE = 3'd1,
        WK_SENSE  = 3'd2,
        WK_PRIO   = 3'd3,
        WK_ROUTE  = 3'd4,
        WK_SETP   = 3'd5,
        WK_CLRP   = 3'd6,
        WK_SOFT   = 3'd7
    } wr_kind_e;

    localparam int SOFT_IDS = 16;
    localparam int PRIV_IDS = 16;
    localparam int PRIO_RST = 8'hA0;

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_dist_pkg::*;
#(
    parameter int ID      = 0,
    parameter int NUM_CPU = 2,
    parameter int PRIO_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_i,
    input  logic                sel_i,
    input  logic [2:0]          kind_i,
    input  logic [PRIO_W-1:0]   data_i,
    input  logic                ack_i,
    input  logic                eoi_i,
    output irq_state_e          state_o,
    output logic                en_o,
    output logic [PRIO_W-1:0]   prio_o,
    output logic [NUM_CPU-1:0]  tgt_o
);

    localparam bit IS_SOFT   = (ID < SOFT_IDS);
    localparam bit IS_PRIV   = !IS_SOFT && (ID < SOFT_IDS + PRIV_IDS);
    localparam bit IS_SHARED = !IS_SOFT && !IS_PRIV;
    localparam int OWNER     = IS_PRIV ? ((ID - SOFT_IDS) * NUM_CPU) / PRIV_IDS : 0;
    localparam logic [NUM_CPU-1:0] TGT_RST =
        IS_PRIV ? NUM_CPU'(1 << OWNER) : (IS_SHARED ? NUM_CPU'(1) : '0);

    wr_kind_e    kind;
    irq_state_e  state_q, state_d;
    logic [1:0]  hist_q;
    logic        sense_edge_q;
    logic        raise_line, lvl_low, sw_set, sw_clr, raise, drop;

    assign kind = wr_kind_e'(kind_i);

    // Two-flop history of the input line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= 2'b00;
        else        hist_q <= {hist_q[0], IS_SOFT ? 1'b0 : line_i};
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o         <= 1'b0;
            sense_edge_q <= IS_SOFT;
            prio_o       <= PRIO_W'(PRIO_RST);
            tgt_o        <= TGT_RST;
        end else if (sel_i) begin
            unique case (kind)
                WK_ENABLE: en_o <= data_i[0];
                WK_SENSE:  if (!IS_SOFT) sense_edge_q <= data_i[0];
                WK_PRIO:   prio_o <= data_i;
                WK_ROUTE:  if (IS_SHARED) tgt_o <= data_i[NUM_CPU-1:0];
                WK_SOFT:   if (IS_SOFT) tgt_o <= data_i[NUM_CPU-1:0];
                default: ;
            endcase
        end
    end

    // Request conditions
    always_comb begin
        if (IS_SOFT)           raise_line = 1'b0;
        else if (sense_edge_q) raise_line = hist_q[0] & ~hist_q[1];
        else                   raise_line = hist_q[0];
        lvl_low = !IS_SOFT && !sense_edge_q && !hist_q[0];
        sw_set  = sel_i && ((kind == WK_SETP) || (IS_SOFT && kind == WK_SOFT));
        sw_clr  = sel_i && (kind == WK_CLRP);
        raise   = raise_line || sw_set;
        drop    = sw_clr || (lvl_low && !sw_set);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (raise && !sw_clr) state_d = ST_PEND;
            end
            ST_PEND: begin
                if (ack_i)     state_d = raise ? ST_ACTPEND : ST_ACT;
                else if (drop) state_d = ST_IDLE;
            end
            ST_ACT: begin
                if (eoi_i)                  state_d = (raise && !sw_clr) ? ST_PEND : ST_IDLE;
                else if (raise && !sw_clr)  state_d = ST_ACTPEND;
            end
            ST_ACTPEND: begin
                if (eoi_i)     state_d = drop ? ST_IDLE : ST_PEND;
                else if (drop) state_d = ST_ACT;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_ID  = 48,
    parameter int NUM_CPU = 2,
    parameter int PRIO_W  = 8,
    parameter int IDW     = 6
) (
    input  logic                       gen_en,
    input  logic [NUM_ID-1:0]          cand,
    input  logic [NUM_ID*PRIO_W-1:0]   prio_flat,
    input  logic [NUM_ID*NUM_CPU-1:0]  tgt_flat,
    output logic [NUM_CPU-1:0]         sel_valid,
    output logic [NUM_CPU*IDW-1:0]     sel_id,
    output logic [NUM_CPU*PRIO_W-1:0]  sel_prio
);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_port
        logic              found;
        logic [IDW-1:0]    best_id;
        logic [PRIO_W-1:0] best_prio;

        // Ascending scan with strict compare keeps the lower ID on ties
        always_comb begin
            found     = 1'b0;
            best_id   = '0;
            best_prio = '1;
            for (int i = 0; i < NUM_ID; i++) begin
                if (gen_en && cand[i] && tgt_flat[i*NUM_CPU+c] &&
                    (!found || prio_flat[i*PRIO_W +: PRIO_W] < best_prio)) begin
                    found     = 1'b1;
                    best_id   = IDW'(i);
                    best_prio = prio_flat[i*PRIO_W +: PRIO_W];
                end
            end
        end

        assign sel_valid[c]              = found;
        assign sel_id[c*IDW +: IDW]      = best_id;
        assign sel_prio[c*PRIO_W +: PRIO_W] = best_prio;
    end

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irq_dist_pkg::*;
#(
    parameter int  NUM_LINES = 32,
    parameter int  NUM_CPU   = 2,
    parameter int  PRIO_W    = 8,
    localparam int NUM_ID    = SOFT_IDS + NUM_LINES,
    localparam int IDW       = $clog2(NUM_ID)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LINES-1:0]       irq_lines,
    input  logic                       wr_en,
    input  logic [2:0]                 wr_kind,
    input  logic [IDW-1:0]             wr_id,
    input  logic [PRIO_W-1:0]          wr_data,
    input  logic [NUM_CPU-1:0]         ack,
    input  logic [NUM_CPU-1:0]         eoi,
    input  logic [NUM_CPU*IDW-1:0]     eoi_id,
    output logic [NUM_CPU-1:0]         irq_valid,
    output logic [NUM_CPU*IDW-1:0]     irq_id,
    output logic [NUM_CPU*PRIO_W-1:0]  irq_prio
);

    logic                       gen_en;
    logic [NUM_ID-1:0]          cand;
    logic [NUM_ID-1:0]          en_vec;
    logic [NUM_ID*2-1:0]        st_flat;
    logic [NUM_ID*PRIO_W-1:0]   prio_flat;
    logic [NUM_ID*NUM_CPU-1:0]  tgt_flat;

    // Global forwarding enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  gen_en <= 1'b0;
        else if (wr_en && wr_kind_e'(wr_kind) == WK_GCTL) gen_en <= wr_data[0];
    end

    for (genvar i = 0; i < NUM_ID; i++) begin : g_slot
        logic       line, sel, ack_hit, eoi_hit;
        irq_state_e st;

        if (i < SOFT_IDS) begin : g_soft
            assign line = 1'b0;
        end else begin : g_wired
            assign line = irq_lines[i-SOFT_IDS];
        end

        assign sel = wr_en && (wr_id == IDW'(i));

        always_comb begin
            ack_hit = 1'b0;
            eoi_hit = 1'b0;
            for (int c = 0; c < NUM_CPU; c++) begin
                if (ack[c] && irq_valid[c] && irq_id[c*IDW +: IDW] == IDW'(i)) ack_hit = 1'b1;
                if (eoi[c] && eoi_id[c*IDW +: IDW] == IDW'(i))                 eoi_hit = 1'b1;
            end
        end

        irq_src_slot #(
            .ID      (i),
            .NUM_CPU (NUM_CPU),
            .PRIO_W  (PRIO_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (line),
            .sel_i   (sel),
            .kind_i  (wr_kind),
            .data_i  (wr_data),
            .ack_i   (ack_hit),
            .eoi_i   (eoi_hit),
            .state_o (st),
            .en_o    (en_vec[i]),
            .prio_o  (prio_flat[i*PRIO_W +: PRIO_W]),
            .tgt_o   (tgt_flat[i*NUM_CPU +: NUM_CPU])
        );

        assign st_flat[i*2 +: 2] = st;
        assign cand[i]           = en_vec[i] && (st == ST_PEND);
    end

    irq_arbiter #(
        .NUM_ID  (NUM_ID),
        .NUM_CPU (NUM_CPU),
        .PRIO_W  (PRIO_W),
        .IDW     (IDW)
    ) u_arb (
        .gen_en    (gen_en),
        .cand      (cand),
        .prio_flat (prio_flat),
        .tgt_flat  (tgt_flat),
        .sel_valid (irq_valid),
        .sel_id    (irq_id),
        .sel_prio  (irq_prio)
    );

endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk #(
    parameter int NUM_ID  = 48,
    parameter int NUM_CPU = 2,
    parameter int IDW     = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       gen_en,
    input logic [NUM_ID-1:0]          en_vec,
    input logic [NUM_ID*2-1:0]        st_flat,
    input logic [NUM_ID*NUM_CPU-1:0]  tgt_flat,
    input logic [NUM_CPU-1:0]         ack,
    input logic [NUM_CPU-1:0]         eoi,
    input logic [NUM_CPU*IDW-1:0]     eoi_id,
    input logic [NUM_CPU-1:0]         irq_valid,
    input logic [NUM_CPU*IDW-1:0]     irq_id
);

    function automatic logic [1:0] st_of(input logic [IDW-1:0] id);
        st_of = 2'd0;
        for (int i = 0; i < NUM_ID; i++)
            if (id == IDW'(i)) st_of = st_flat[i*2 +: 2];
    endfunction

    function automatic logic eligible(input logic [IDW-1:0] id, input int c);
        eligible = 1'b0;
        for (int i = 0; i < NUM_ID; i++)
            if (id == IDW'(i))
                eligible = en_vec[i] && (st_flat[i*2 +: 2] == 2'd1) && tgt_flat[i*NUM_CPU+c];
    endfunction

    // R2
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |-> (irq_valid == '0));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_port
        logic [IDW-1:0] eid;
        logic [IDW-1:0] eid_q;
        logic           in_service_eoi;
        assign eid = eoi_id[c*IDW +: IDW];
        assign in_service_eoi = eoi[c] && st_of(eid)[1];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) eid_q <= '0;
            else        eid_q <= eid;
        end

        // R4
        shown_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_valid[c] |-> eligible(irq_id[c*IDW +: IDW], c));

        // R7
        ack_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[c] && irq_valid[c]) |=>
                !(irq_valid[c] && irq_id[c*IDW +: IDW] == $past(irq_id[c*IDW +: IDW])));

        // R9
        eoi_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_service_eoi |=> !st_of(eid_q)[1]);
    end

endmodule

bind irq_distributor irq_dist_chk #(
    .NUM_ID  (NUM_ID),
    .NUM_CPU (NUM_CPU),
    .IDW     (IDW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en    (gen_en),
    .en_vec    (en_vec),
    .st_flat   (st_flat),
    .tgt_flat  (tgt_flat),
    .ack       (ack),
    .eoi       (eoi),
    .eoi_id    (eoi_id),
    .irq_valid (irq_valid),
    .irq_id    (irq_id)
);

// File: tb/tb_irq_distributor.sv
module tb_irq_distributor;

    localparam int CLK_PERIOD = 10;
    localparam int NL   = 32;
    localparam int NC   = 2;
    localparam int PW   = 8;
    localparam int IDW  = 6;
    localparam int NVEC = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NL-1:0]     irq_lines = '0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_kind = '0;
    logic [IDW-1:0]    wr_id = '0;
    logic [PW-1:0]     wr_data = '0;
    logic [NC-1:0]     ack = '0;
    logic [NC-1:0]     eoi = '0;
    logic [NC*IDW-1:0] eoi_id = '0;
    logic [NC-1:0]     irq_valid;
    logic [NC*IDW-1:0] irq_id;
    logic [NC*PW-1:0]  irq_prio;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_distributor #(.NUM_LINES(NL), .NUM_CPU(NC), .PRIO_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_id(wr_id), .wr_data(wr_data),
        .ack(ack), .eoi(eoi), .eoi_id(eoi_id),
        .irq_valid(irq_valid), .irq_id(irq_id), .irq_prio(irq_prio)
    );

    // {wr_kind, wr_id, wr_data, exp_v0, exp_id0, exp_v1, exp_id1}
    localparam logic [30:0] VEC [NVEC] = '{
        {3'd0, 6'd0, 8'h01, 1'b0, 6'd0, 1'b0, 6'd0},   // R2 enable forwarding
        {3'd1, 6'd3, 8'h01, 1'b0, 6'd0, 1'b0, 6'd0},   // R3
        {3'd3, 6'd3, 8'h40, 1'b0, 6'd0, 1'b0, 6'd0},
        {3'd7, 6'd3, 8'h02, 1'b0, 6'd0, 1'b1, 6'd3},   // R10 to port 1
        {3'd1, 6'd5, 8'h01, 1'b0, 6'd0, 1'b1, 6'd3},
        {3'd3, 6'd5, 8'h40, 1'b0, 6'd0, 1'b1, 6'd3},
        {3'd7, 6'd5, 8'h03, 1'b1, 6'd5, 1'b1, 6'd3},   // R4 tie -> lower ID
        {3'd3, 6'd5, 8'h30, 1'b1, 6'd5, 1'b1, 6'd5},   // R4 lower value wins
        {3'd6, 6'd5, 8'h00, 1'b0, 6'd0, 1'b1, 6'd3},   // R11 clear
        {3'd1, 6'd3, 8'h00, 1'b0, 6'd0, 1'b0, 6'd0},   // R3 disabled
        {3'd1, 6'd3, 8'h01, 1'b0, 6'd0, 1'b1, 6'd3},
        {3'd0, 6'd0, 8'h00, 1'b0, 6'd0, 1'b0, 6'd0},   // R2 off
        {3'd0, 6'd0, 8'h01, 1'b0, 6'd0, 1'b1, 6'd3},
        {3'd5, 6'd5, 8'h00, 1'b1, 6'd5, 1'b1, 6'd5},   // R11 set
        {3'd6, 6'd3, 8'h00, 1'b1, 6'd5, 1'b1, 6'd5},
        {3'd6, 6'd5, 8'h00, 1'b0, 6'd0, 1'b0, 6'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic port_is(input string req, input int c, input logic v, input logic [IDW-1:0] id);
        check({req, " valid"}, 32'(irq_valid[c]), 32'(v));
        if (v) check({req, " id"}, 32'(irq_id[c*IDW +: IDW]), 32'(id));
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] k, input logic [IDW-1:0] id, input logic [PW-1:0] d);
        wr_en = 1'b1; wr_kind = k; wr_id = id; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ack(input int c);
        ack[c] = 1'b1;
        step(1);
        ack[c] = 1'b0;
    endtask

    task automatic pulse_eoi(input int c, input logic [IDW-1:0] id);
        eoi[c] = 1'b1;
        eoi_id[c*IDW +: IDW] = id;
        step(1);
        eoi[c] = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 no valid after reset", 32'(irq_valid), 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            wr(VEC[v][30:28], VEC[v][27:22], VEC[v][21:14]);
            port_is($sformatf("vec %0d R4", v), 0, VEC[v][13], VEC[v][12:7]);
            port_is($sformatf("vec %0d R4", v), 1, VEC[v][6],  VEC[v][5:0]);
        end

        // R5 edge-triggered shared ID 40 (line bit 24)
        wr(3'd1, 6'd40, 8'h01);
        wr(3'd2, 6'd40, 8'h01);
        wr(3'd3, 6'd40, 8'h20);
        irq_lines[24] = 1'b1;
        step(1);
        port_is("R5 not yet", 0, 1'b0, 6'd0);
        step(1);
        port_is("R5 edge pending", 0, 1'b1, 6'd40);
        check("R5 prio", 32'(irq_prio[PW-1:0]), 32'h20);
        pulse_ack(0);
        port_is("R7 ack hides", 0, 1'b0, 6'd0);
        irq_lines[24] = 1'b0; step(2);
        irq_lines[24] = 1'b1; step(2);
        port_is("R8 new edge hidden", 0, 1'b0, 6'd0);
        irq_lines[24] = 1'b0; step(2);
        irq_lines[24] = 1'b1; step(2);
        port_is("R8 second edge hidden", 0, 1'b0, 6'd0);
        pulse_eoi(0, 6'd40);
        port_is("R9 back to pending", 0, 1'b1, 6'd40);
        pulse_ack(0);
        pulse_eoi(0, 6'd40);
        step(3);
        port_is("R9 R5 idle with line high", 0, 1'b0, 6'd0);
        irq_lines[24] = 1'b0;

        // R6 level-sensitive shared ID 33 (line bit 17)
        wr(3'd1, 6'd33, 8'h01);
        wr(3'd3, 6'd33, 8'h10);
        irq_lines[17] = 1'b1; step(2);
        port_is("R6 level pending", 0, 1'b1, 6'd33);
        irq_lines[17] = 1'b0; step(2);
        port_is("R6 level dropped", 0, 1'b0, 6'd0);
        irq_lines[17] = 1'b1; step(2);
        pulse_ack(0);
        port_is("R7 level ack hidden", 0, 1'b0, 6'd0);
        pulse_eoi(0, 6'd33);
        port_is("R7 R9 level still pending", 0, 1'b1, 6'd33);
        irq_lines[17] = 1'b0; step(2);
        port_is("R6 drop after eoi", 0, 1'b0, 6'd0);

        // R1 default priority and routing of shared ID 34 (line bit 18)
        wr(3'd1, 6'd34, 8'h01);
        irq_lines[18] = 1'b1; step(2);
        port_is("R1 default route", 0, 1'b1, 6'd34);
        check("R1 default prio", 32'(irq_prio[PW-1:0]), 32'hA0);
        wr(3'd4, 6'd34, 8'h02);
        port_is("R4 reroute off port 0", 0, 1'b0, 6'd0);
        port_is("R4 reroute to port 1", 1, 1'b1, 6'd34);
        irq_lines[18] = 1'b0; step(2);
        port_is("R6 port 1 cleared", 1, 1'b0, 6'd0);

        // R12 private IDs: 28 owned by port 1, 20 by port 0
        wr(3'd1, 6'd28, 8'h01);
        wr(3'd4, 6'd28, 8'h01);
        irq_lines[12] = 1'b1; step(2);
        port_is("R12 private route ignored p0", 0, 1'b0, 6'd0);
        port_is("R12 private owner p1", 1, 1'b1, 6'd28);
        wr(3'd1, 6'd20, 8'h01);
        irq_lines[4] = 1'b1; step(2);
        port_is("R12 private owner p0", 0, 1'b1, 6'd20);

        finish_run();
    end

endmodule